// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out the low four bits of a bus slave address, and two pull-up group enables, from two address-select pins. Each pin may be strapped to ground or to supply, or wired to the bus clock (SCL) or the bus data line (SDA). A static strap is easy to read. A pin wired to a bus line only shows itself while the bus moves, so the block watches each pin across a whole bus transaction. It compares the pin with SCL and SDA on every sampled cycle and stores the resulting connection when the transaction closes.

The decode runs on every transaction on the bus, whatever device is addressed, so the strapping can change while the part stays powered. Until the first transaction has closed, a pin is read from its present level: high means supply and low means ground. On an idle bus both lines are high, so a pin wired to SCL or SDA reads as supply. An address comparison that is already under way keeps using the stored result. The new result becomes visible in the cycle after STOP.

The inputs are the synchronized pin levels, SCL, SDA and single-cycle START and STOP indications from the bus front end. The outputs are the four address bits and one pull-up enable for each group of four inputs.

Top module: `addr_pin_decoder`

## Requirements
- R1: Before any transaction has closed, each pin's connection follows its present level: high reads as supply and low reads as ground.
- R2: The upper pin drives addr[3:2] with this code: SCL gives 00, SDA gives 01, ground gives 10 and supply gives 11.
- R3: The lower pin drives addr[1:0] with this code: ground gives 00, supply gives 01, SCL gives 10 and SDA gives 11.
- R4: pu_hi is low exactly when the upper pin is classed as ground, and pu_lo is low exactly when the lower pin is classed as ground. Every other connection drives the enable high.
- R5: A pin that equalled SCL on every sampled cycle of a transaction, and differed from SDA on at least one, is classed as SCL.
- R6: A pin that equalled SDA on every sampled cycle, and differed from SCL on at least one, is classed as SDA.
- R7: A pin that matched neither line on every sampled cycle is classed as static. It reads as supply if its level in the STOP cycle is high, and as ground if that level is low.
- R8: A transaction samples from its opening START cycle up to the cycle before STOP. The stored class changes only on STOP and shows on the outputs one cycle after the STOP indication.
- R9: A pin that matched both SCL and SDA on every sampled cycle keeps its previous class. If it has none, it keeps following its level.
- R10: A START while a transaction is open (repeated START) does not restart sampling. That cycle is sampled as part of the same transaction.
- R11: START and STOP in the same cycle of an open transaction first close it, using the samples before that cycle. They then open a new transaction whose first sample is that cycle.
- R12: A STOP while no transaction is open has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_hi | input | 1 | Synchronized level of the upper address pin |
| pin_lo | input | 1 | Synchronized level of the lower address pin |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| start_det | input | 1 | One-cycle START (or repeated START) indication |
| stop_det | input | 1 | One-cycle STOP indication |
| addr | output | 4 | Low slave-address bits |
| pu_hi | output | 1 | Pull-up enable for inputs 7 to 4 |
| pu_lo | output | 1 | Pull-up enable for inputs 3 to 0 |

## Verification
The closing of one sampling window and the opening of the next can fall in one cycle, when START and STOP are flagged together. The bench provokes this in the middle of a transaction in which the upper pin follows SCL and the lower pin follows SDA, and then swaps the two wirings for the new transaction. The result is judged by the address seen just after the shared cycle, which must show the old wiring, and by the address after the following STOP, which must show the swapped wiring. A reference model in the bench, built from the window rules, predicts every cycle and also covers repeated START and STOP on an idle bus.

// File: rtl/addr_sel_pkg.sv
package addr_sel_pkg;

   // Connection class of one address-select pin.
   typedef enum logic [1:0] {
      CONN_GND = 2'd0,
      CONN_VDD = 2'd1,
      CONN_SCL = 2'd2,
      CONN_SDA = 2'd3
   } conn_e;

   // Window control strobes shared by all pin trackers.
   typedef struct packed {
      logic open;   // first sample of a new transaction
      logic acc;    // further sample inside an open transaction
      logic close;  // transaction ends, decide and latch
   } win_ctl_t;

endpackage

// File: rtl/addr_window_ctl.sv
module addr_window_ctl
   import addr_sel_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_det,
   input  logic     stop_det,
   output win_ctl_t win
);

   logic busy_q;
   logic close_now;
   logic open_now;

   // STOP only counts when a transaction is open; START opens one if the
   // bus is idle, or right after a close in the same cycle.
   assign close_now = stop_det && busy_q;
   assign open_now  = start_det && (!busy_q || close_now);

   always_comb begin
      win.close = close_now;
      win.open  = open_now;
      win.acc   = busy_q && !stop_det && !open_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (open_now) begin
         busy_q <= 1'b1;
      end else if (close_now) begin
         busy_q <= 1'b0;
      end
   end

   // R12: a STOP on an idle bus leaves the bus idle
   a_r12_idle_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && stop_det && !start_det) |=> !busy_q);

   // R10: a repeated START keeps the transaction open
   a_r10_restart_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_det && !stop_det) |=> busy_q);

   // R11: START together with STOP leaves a fresh transaction open
   a_r11_close_and_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_det && stop_det) |=> busy_q);

endmodule

// File: rtl/addr_pin_tracker.sv
module addr_pin_tracker
   import addr_sel_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin,
   input  logic     scl,
   input  logic     sda,
   input  win_ctl_t win,
   output conn_e    conn_o
);

   logic  all_scl_q;   // pin equalled SCL on every sample so far
   logic  all_sda_q;   // pin equalled SDA on every sample so far
   logic  have_q;      // a class has been latched since reset
   conn_e class_q;
   logic  eq_scl;
   logic  eq_sda;
   logic  keep;
   conn_e decided;

   assign eq_scl = (pin == scl);
   assign eq_sda = (pin == sda);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_scl_q <= 1'b1;
         all_sda_q <= 1'b1;
      end else if (win.open) begin
         all_scl_q <= eq_scl;
         all_sda_q <= eq_sda;
      end else if (win.acc) begin
         all_scl_q <= all_scl_q && eq_scl;
         all_sda_q <= all_sda_q && eq_sda;
      end
   end

   // Decision uses the samples before the closing cycle; the static level
   // is the pin value in the closing cycle.
   always_comb begin
      keep    = 1'b0;
      decided = pin ? CONN_VDD : CONN_GND;
      unique case ({all_scl_q, all_sda_q})
         2'b10:   decided = CONN_SCL;
         2'b01:   decided = CONN_SDA;
         2'b11:   keep    = 1'b1;
         default: decided = pin ? CONN_VDD : CONN_GND;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q  <= 1'b0;
         class_q <= CONN_GND;
      end else if (win.close && !keep) begin
         have_q  <= 1'b1;
         class_q <= decided;
      end
   end

   assign conn_o = have_q ? class_q : (pin ? CONN_VDD : CONN_GND);

   // R8: the stored class moves only when a transaction closes
   a_r8_class_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !win.close |=> ($stable(class_q) && $stable(have_q)));

   // R9: a pin that could not be told apart keeps what it had
   a_r9_ambiguous_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (win.close && all_scl_q && all_sda_q) |=> ($stable(class_q) && $stable(have_q)));

   // R8: window strobes never overlap in a way that loses a sample
   a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win.open, win.acc}));

endmodule

// File: rtl/addr_code_map.sv
module addr_code_map
   import addr_sel_pkg::*;
#(
   parameter bit UPPER_PIN = 1'b0,
   parameter int CODE_W    = 2
) (
   input  conn_e             conn,
   output logic [CODE_W-1:0] code,
   output logic              pu_en
);

   if (CODE_W != 2) begin : g_bad_width
      $error("addr_code_map: CODE_W must be 2");
   end

   if (UPPER_PIN) begin : g_upper
      always_comb begin
         unique case (conn)
            CONN_SCL: code = 2'b00;
            CONN_SDA: code = 2'b01;
            CONN_GND: code = 2'b10;
            default:  code = 2'b11;
         endcase
      end
   end else begin : g_lower
      always_comb begin
         unique case (conn)
            CONN_GND: code = 2'b00;
            CONN_VDD: code = 2'b01;
            CONN_SCL: code = 2'b10;
            default:  code = 2'b11;
         endcase
      end
   end

   assign pu_en = (conn != CONN_GND);

endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
   import addr_sel_pkg::*;
#(
   parameter  int NUM_PINS = 2,
   parameter  int CODE_W   = 2,
   localparam int ADDR_W   = NUM_PINS * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_hi,
   input  logic              pin_lo,
   input  logic              scl,
   input  logic              sda,
   input  logic              start_det,
   input  logic              stop_det,
   output logic [ADDR_W-1:0] addr,
   output logic              pu_hi,
   output logic              pu_lo
);

   if (NUM_PINS != 2) begin : g_bad_pins
      $error("addr_pin_decoder: NUM_PINS must be 2");
   end

   win_ctl_t              win;
   logic [NUM_PINS-1:0]   pin_vec;
   logic [NUM_PINS-1:0]   pu_vec;
   conn_e                 conn [NUM_PINS];

   assign pin_vec = {pin_hi, pin_lo};

   addr_window_ctl u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_det (start_det),
      .stop_det  (stop_det),
      .win       (win)
   );

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      addr_pin_tracker u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin    (pin_vec[g]),
         .scl    (scl),
         .sda    (sda),
         .win    (win),
         .conn_o (conn[g])
      );

      addr_code_map #(
         .UPPER_PIN (g == NUM_PINS-1),
         .CODE_W    (CODE_W)
      ) u_map (
         .conn  (conn[g]),
         .code  (addr[g*CODE_W +: CODE_W]),
         .pu_en (pu_vec[g])
      );
   end

   assign pu_hi = pu_vec[NUM_PINS-1];
   assign pu_lo = pu_vec[0];

   // R4: upper enable low exactly when the upper code reads ground (10)
   a_r4_pu_hi_vs_addr: assert property (@(posedge clk) disable iff (!rst_n)
      pu_hi == (addr[ADDR_W-1 -: CODE_W] != 2'b10));

   // R4: lower enable low exactly when the lower code reads ground (00)
   a_r4_pu_lo_vs_addr: assert property (@(posedge clk) disable iff (!rst_n)
      pu_lo == (addr[CODE_W-1:0] != 2'b00));

endmodule

// File: tb/addr_pin_decoder_test.sv
module addr_pin_decoder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_hi = 1'b1, pin_lo = 1'b1;
   logic       scl = 1'b1, sda = 1'b1;
   logic       start_det = 1'b0, stop_det = 1'b0;
   logic [3:0] addr;
   logic       pu_hi, pu_lo;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   addr_pin_decoder uut (
      .clk(clk), .rst_n(rst_n), .pin_hi(pin_hi), .pin_lo(pin_lo),
      .scl(scl), .sda(sda), .start_det(start_det), .stop_det(stop_det),
      .addr(addr), .pu_hi(pu_hi), .pu_lo(pu_lo)
   );

   // Bench wiring kinds: 0 ground, 1 supply, 2 SCL, 3 SDA
   int chi = 0, clo = 1;

   // Scoreboard queues
   logic [3:0] q_addr[$];
   logic       q_phi[$];
   logic       q_plo[$];
   string      q_tag[$];

   // Reference model state (index 1 upper pin, 0 lower pin)
   bit m_busy = 0;
   bit m_scl[2] = '{1, 1};
   bit m_sda[2] = '{1, 1};
   bit m_have[2] = '{0, 0};
   int m_cls[2] = '{0, 0};

   function automatic logic pin_of(int c, logic s, logic d);
      case (c)
         0: return 1'b0;
         1: return 1'b1;
         2: return s;
         default: return d;
      endcase
   endfunction

   function automatic logic [1:0] code_upper(int c);   // R2
      case (c)
         2: return 2'b00;
         3: return 2'b01;
         0: return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   function automatic logic [1:0] code_lower(int c);   // R3
      case (c)
         0: return 2'b00;
         1: return 2'b01;
         2: return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   task automatic step(input logic s, input logic d, input logic st,
                       input logic sp, input string tag);
      logic pv[2];
      bit closing, opening, accum;
      int eff[2];
      pv[1] = pin_of(chi, s, d);
      pv[0] = pin_of(clo, s, d);
      closing = sp && m_busy;
      opening = st && (!m_busy || closing);
      accum   = m_busy && !sp && !opening;
      for (int p = 0; p < 2; p++) begin
         if (closing) begin
            if (m_scl[p] && !m_sda[p]) begin m_cls[p] = 2; m_have[p] = 1; end
            else if (m_sda[p] && !m_scl[p]) begin m_cls[p] = 3; m_have[p] = 1; end
            else if (!(m_scl[p] && m_sda[p])) begin m_cls[p] = pv[p] ? 1 : 0; m_have[p] = 1; end
         end
         if (opening) begin
            m_scl[p] = (pv[p] == s);
            m_sda[p] = (pv[p] == d);
         end else if (accum) begin
            m_scl[p] = m_scl[p] && (pv[p] == s);
            m_sda[p] = m_sda[p] && (pv[p] == d);
         end
         eff[p] = m_have[p] ? m_cls[p] : (pv[p] ? 1 : 0);
      end
      if (opening) m_busy = 1;
      else if (closing) m_busy = 0;
      scl = s; sda = d; start_det = st; stop_det = sp;
      pin_hi = pv[1]; pin_lo = pv[0];
      q_addr.push_back({code_upper(eff[1]), code_lower(eff[0])});
      q_phi.push_back(eff[1] != 0);
      q_plo.push_back(eff[0] != 0);
      q_tag.push_back(tag);
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 1, 0, 0, tag);
   endtask

   task automatic send_byte(input logic [7:0] b, input string tag);
      for (int i = 7; i >= 0; i--) begin
         step(0, b[i], 0, 0, tag);
         step(1, b[i], 0, 0, tag);
      end
   endtask

   task automatic finish_txn(input string tag);
      step(0, 0, 0, 0, tag);
      step(1, 0, 0, 0, tag);
      step(1, 1, 0, 1, tag);
   endtask

   task automatic txn(input logic [7:0] b, input string tag);
      step(1, 0, 1, 0, tag);
      send_byte(b, tag);
      finish_txn(tag);
   endtask

   // Monitor: compares away from the active edge
   always @(posedge clk) begin
      #5;
      if (q_addr.size() > 0) begin
         logic [3:0] ea;
         logic eh, el;
         string t;
         ea = q_addr.pop_front();
         eh = q_phi.pop_front();
         el = q_plo.pop_front();
         t  = q_tag.pop_front();
         checks++;
         if (addr !== ea || pu_hi !== eh || pu_lo !== el) begin
            errors++;
            $display("FAIL %s: addr=%h pu_hi=%b pu_lo=%b, expected addr=%h pu_hi=%b pu_lo=%b",
                     t, addr, pu_hi, pu_lo, ea, eh, el);
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1, R2, R3, R4: static straps before any transaction, upper ground, lower supply -> 9
      chi = 0; clo = 1;
      idle(3, "R1");
      // R1: bus-wired pins read as supply on an idle bus -> D
      chi = 2; clo = 3;
      idle(3, "R1");
      // R5, R6: first transaction classifies SCL/SDA -> 3
      txn(8'hA5, "R5");
      idle(3, "R6");
      // R5, R6 swapped wiring, outputs held during the window (R8) -> 6
      chi = 3; clo = 2;
      txn(8'h3C, "R8");
      idle(3, "R6");
      // R7, R4: static supply upper, ground lower -> C, pu_lo low
      chi = 1; clo = 0;
      txn(8'h96, "R7");
      idle(3, "R4");
      // R9: SCL and SDA move together; upper on SCL ambiguous keeps supply, lower ground
      chi = 2; clo = 0;
      step(1, 1, 1, 0, "R9");
      for (int i = 0; i < 6; i++) begin
         step(0, 0, 0, 0, "R9");
         step(1, 1, 0, 0, "R9");
      end
      step(1, 1, 0, 1, "R9");
      idle(3, "R9");
      // R10: repeated START must not restart sampling; upper on ground, then SCL
      chi = 0; clo = 3;
      step(1, 0, 1, 0, "R10");
      send_byte(8'h5A, "R10");
      chi = 2;
      step(1, 1, 0, 0, "R10");
      step(1, 0, 1, 0, "R10");
      send_byte(8'hC3, "R10");
      finish_txn("R10");
      idle(3, "R10");
      // R11: START and STOP together close one window and open the next
      chi = 2; clo = 3;
      step(1, 0, 1, 0, "R11");
      send_byte(8'h69, "R11");
      step(1, 1, 1, 1, "R11");
      chi = 3; clo = 2;
      send_byte(8'hB4, "R11");
      finish_txn("R11");
      idle(3, "R11");
      // R12: STOP on an idle bus changes nothing even though straps moved
      chi = 0; clo = 0;
      step(1, 1, 0, 1, "R12");
      idle(4, "R12");
      repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule